// File: doc/BRIEF.md
# Authentication Tag Truncation Checker

This block sits behind an AES authentication engine. It takes the 128-bit MAC the engine computed and the 128-bit tag that arrived with the message. It works out how many leading bytes of the tag are significant and compares only those bytes. It returns a pass/fail result and a copy of the computed MAC with the insignificant trailing bytes cleared, ready to go back into context storage.

The compare length depends on the mode:

- **CMAC and GCM** take the length from a programmable size register. Each mode has its own set of accepted values, and any other value means a full 16-byte compare.
- **XCBC-MAC** always checks 12 bytes and always stores the whole MAC.
- **CCM** ignores the size register. It derives the length from the tag-length field of the CCM flags byte.

A start strobe launches one evaluation. The result and a one-cycle done pulse appear on the next clock edge, and the result holds until the following start.

Top module: `tag_trunc_chk`

## Requirements
- R1: In CMAC mode (mode_i = 0), the accepted size-register values are 8, 10, 12, 14 and 16. With one of these values n, mismatch_o is 1 exactly when one of the first n tag bytes (counting from bit 127 downward) differs between calc_mac_i and rx_tag_i.
- R2: In GCM mode (mode_i = 1), the accepted size-register values are 8, 12 and 16, with the same compare rule as R1.
- R3: In CMAC or GCM mode, any other size-register value, including 10 and 14 in GCM mode, gives a 16-byte compare and a 16-byte stored MAC.
- R4: In CMAC, GCM and CCM modes, mac_o holds the first n bytes of calc_mac_i (counting from bit 127 downward), where n is the compare length, and all lower bytes are zero.
- R5: Bytes of rx_tag_i beyond the compare length have no effect on mismatch_o. A tag equal to the computed MAC never mismatches.
- R6: In XCBC-MAC mode (mode_i = 2), the size register is ignored and only the first 12 bytes are compared.
- R7: In XCBC-MAC mode, mac_o is the full 16-byte calc_mac_i.
- R8: In CCM mode (mode_i = 3), the size register is ignored. With t = ccm_flags_i[5:3], the length is 2*t+2 bytes for t from 2 to 7. For t = 0 or t = 1 the length is 16 bytes.
- R9: The size register loads size_wdata_i on a clock edge where size_we_i is 1, and resets to 0, which selects a 16-byte compare.
- R10: done_o is 1 for exactly the cycle after each cycle in which start_i is 1. mac_o and mismatch_o update only on that edge and hold otherwise. Reset clears all three outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| size_we_i | input | 1 | Size-register write enable |
| size_wdata_i | input | 5 | Size-register write value, in bytes |
| mode_i | input | 2 | 0 CMAC, 1 GCM, 2 XCBC-MAC, 3 CCM |
| ccm_flags_i | input | 8 | CCM flags byte; bits 5:3 encode the tag length |
| calc_mac_i | input | 128 | Computed MAC, first byte in bits 127:120 |
| rx_tag_i | input | 128 | Received tag, padded to 16 bytes |
| start_i | input | 1 | Evaluate on this edge |
| mac_o | output | 128 | Truncated computed MAC for storage |
| mismatch_o | output | 1 | 1 when the compared bytes differ |
| done_o | output | 1 | One-cycle result strobe |

## Verification
The assertions check the timing and structural properties on every cycle:
- the done strobe follows each start;
- the outputs hold between starts;
- the stored MAC never has a bit set that is clear in the computed MAC;
- the leading 8 bytes survive in CMAC and GCM, and the whole MAC survives in XCBC-MAC;
- identical tags always pass.

The exact length chosen for each mode and size value can only be shown by the bench's scenarios. These include illegal-size fallback, reserved CCM codes, the effect of the size register's reset value, and which single flipped byte does or does not cause a mismatch.

// File: rtl/tag_trunc_pkg.sv
package tag_trunc_pkg;
  localparam int unsigned TAG_BYTES      = 16;
  localparam int unsigned TAG_W          = TAG_BYTES * 8;
  localparam int unsigned LEN_W          = $clog2(TAG_BYTES + 1);
  localparam int unsigned XCBC_CMP_BYTES = 12;

  typedef enum logic [1:0] {
    MODE_CMAC = 2'd0,
    MODE_GCM  = 2'd1,
    MODE_XCBC = 2'd2,
    MODE_CCM  = 2'd3
  } auth_mode_e;

  typedef logic [LEN_W-1:0] len_t;
endpackage

// File: rtl/tag_len_decode.sv
module tag_len_decode
  import tag_trunc_pkg::*;
(
  input  auth_mode_e  mode_i,
  input  len_t        size_i,
  input  logic [7:0]  ccm_flags_i,
  output len_t        cmp_len_o,
  output len_t        store_len_o
);
  localparam len_t FULL_LEN = len_t'(TAG_BYTES);
  localparam len_t XCBC_LEN = len_t'(XCBC_CMP_BYTES);

  logic cmac_ok, gcm_ok;
  len_t ccm_t, ccm_len;

  assign cmac_ok = size_i inside {len_t'(8), len_t'(10), len_t'(12), len_t'(14), len_t'(16)};
  assign gcm_ok  = size_i inside {len_t'(8), len_t'(12), len_t'(16)};

  // tag-length field: 2*t+2 bytes, codes 0 and 1 reserved
  assign ccm_t   = len_t'(ccm_flags_i[5:3]);
  assign ccm_len = (ccm_t < len_t'(2)) ? FULL_LEN : len_t'((ccm_t << 1) + len_t'(2));

  always_comb begin
    cmp_len_o   = FULL_LEN;
    store_len_o = FULL_LEN;
    unique case (mode_i)
      MODE_CMAC: begin
        cmp_len_o   = cmac_ok ? size_i : FULL_LEN;
        store_len_o = cmp_len_o;
      end
      MODE_GCM: begin
        cmp_len_o   = gcm_ok ? size_i : FULL_LEN;
        store_len_o = cmp_len_o;
      end
      MODE_XCBC: begin
        cmp_len_o   = XCBC_LEN;
        store_len_o = FULL_LEN;
      end
      MODE_CCM: begin
        cmp_len_o   = ccm_len;
        store_len_o = ccm_len;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/byte_mask_gen.sv
module byte_mask_gen #(
  parameter int unsigned NBYTES = 16,
  parameter int unsigned LEN_W  = 5
) (
  input  logic [LEN_W-1:0]    len_i,
  output logic [NBYTES*8-1:0] mask_o
);
  // byte b sits at rank NBYTES-1-b counted from the most significant end
  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    localparam logic [LEN_W-1:0] RANK = LEN_W'(NBYTES - 1 - b);
    assign mask_o[b*8 +: 8] = {8{RANK < len_i}};
  end
endmodule

// File: rtl/tag_compare.sv
module tag_compare #(
  parameter int unsigned W = 128
) (
  input  logic [W-1:0] calc_i,
  input  logic [W-1:0] rx_i,
  input  logic [W-1:0] mask_i,
  output logic         mismatch_o
);
  assign mismatch_o = |((calc_i ^ rx_i) & mask_i);
endmodule

// File: rtl/tag_trunc_chk.sv
module tag_trunc_chk
  import tag_trunc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             size_we_i,
  input  logic [LEN_W-1:0] size_wdata_i,
  input  logic [1:0]       mode_i,
  input  logic [7:0]       ccm_flags_i,
  input  logic [TAG_W-1:0] calc_mac_i,
  input  logic [TAG_W-1:0] rx_tag_i,
  input  logic             start_i,
  output logic [TAG_W-1:0] mac_o,
  output logic             mismatch_o,
  output logic             done_o
);
  localparam int unsigned HALF = TAG_W / 2;

  auth_mode_e       mode;
  len_t             size_q, cmp_len, store_len;
  logic [TAG_W-1:0] cmp_mask, store_mask;
  logic             mismatch_d;

  assign mode = auth_mode_e'(mode_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        size_q <= '0;
    else if (size_we_i) size_q <= size_wdata_i;
  end

  tag_len_decode u_dec (
    .mode_i      (mode),
    .size_i      (size_q),
    .ccm_flags_i (ccm_flags_i),
    .cmp_len_o   (cmp_len),
    .store_len_o (store_len)
  );

  byte_mask_gen #(.NBYTES(TAG_BYTES), .LEN_W(LEN_W)) u_cmp_mask (
    .len_i  (cmp_len),
    .mask_o (cmp_mask)
  );

  byte_mask_gen #(.NBYTES(TAG_BYTES), .LEN_W(LEN_W)) u_store_mask (
    .len_i  (store_len),
    .mask_o (store_mask)
  );

  tag_compare #(.W(TAG_W)) u_cmp (
    .calc_i     (calc_mac_i),
    .rx_i       (rx_tag_i),
    .mask_i     (cmp_mask),
    .mismatch_o (mismatch_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mac_o      <= '0;
      mismatch_o <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      done_o <= start_i;
      if (start_i) begin
        mac_o      <= calc_mac_i & store_mask;
        mismatch_o <= mismatch_d;
      end
    end
  end

  // R10
  done_after_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> done_o);
  // R10
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !done_o);
  // R10
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> ($stable(mac_o) && $stable(mismatch_o)));
  // R4
  mac_subset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> ((mac_o & ~$past(calc_mac_i)) == '0));
  // R7
  xcbc_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && mode_i == MODE_XCBC) |=> (mac_o == $past(calc_mac_i)));
  // R1
  head_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && mode_i != MODE_CCM) |=> (mac_o[TAG_W-1:HALF] == $past(calc_mac_i[TAG_W-1:HALF])));
  // R5
  equal_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && calc_mac_i == rx_tag_i) |=> !mismatch_o);
endmodule

// File: tb/tag_trunc_chk_bench.sv
`timescale 1ns/1ps
module tag_trunc_chk_bench;
  localparam real HALF_PERIOD = 2.5;
  localparam int  NV = 21;
  localparam int  MAX_CYCLES = 200000;

  // mode[20:19] size[18:14] t[13:11] flip[10:6] mis[5] keep[4:0]; flip is byte rank from MSB, 16 = none
  localparam logic [20:0] VEC [NV] = '{
    {2'd0, 5'd8,  3'd0, 5'd8,  1'b0, 5'd8 },  // R1 R5
    {2'd0, 5'd8,  3'd0, 5'd7,  1'b1, 5'd8 },  // R1
    {2'd0, 5'd10, 3'd0, 5'd10, 1'b0, 5'd10},  // R1 R5
    {2'd0, 5'd10, 3'd0, 5'd9,  1'b1, 5'd10},  // R1
    {2'd0, 5'd14, 3'd0, 5'd14, 1'b0, 5'd14},  // R1
    {2'd0, 5'd16, 3'd0, 5'd15, 1'b1, 5'd16},  // R1
    {2'd0, 5'd9,  3'd0, 5'd12, 1'b1, 5'd16},  // R3
    {2'd1, 5'd12, 3'd0, 5'd12, 1'b0, 5'd12},  // R2 R5
    {2'd1, 5'd12, 3'd0, 5'd11, 1'b1, 5'd12},  // R2
    {2'd1, 5'd10, 3'd0, 5'd12, 1'b1, 5'd16},  // R3
    {2'd1, 5'd14, 3'd0, 5'd15, 1'b1, 5'd16},  // R3
    {2'd1, 5'd8,  3'd0, 5'd16, 1'b0, 5'd8 },  // R2 R4
    {2'd2, 5'd8,  3'd0, 5'd12, 1'b0, 5'd16},  // R6 R7
    {2'd2, 5'd16, 3'd0, 5'd11, 1'b1, 5'd16},  // R6
    {2'd3, 5'd16, 3'd3, 5'd8,  1'b0, 5'd8 },  // R8
    {2'd3, 5'd16, 3'd3, 5'd7,  1'b1, 5'd8 },  // R8
    {2'd3, 5'd16, 3'd2, 5'd6,  1'b0, 5'd6 },  // R8
    {2'd3, 5'd8,  3'd7, 5'd15, 1'b1, 5'd16},  // R8
    {2'd3, 5'd8,  3'd0, 5'd15, 1'b1, 5'd16},  // R8 reserved
    {2'd3, 5'd8,  3'd1, 5'd12, 1'b1, 5'd16},  // R8 reserved
    {2'd3, 5'd8,  3'd5, 5'd12, 1'b0, 5'd12}   // R8
  };

  logic         clk, rst_n;
  logic         size_we;
  logic [4:0]   size_wdata;
  logic [1:0]   mode;
  logic [7:0]   flags;
  logic [127:0] calc, rx;
  logic         start;
  logic [127:0] mac;
  logic         mis, done;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  tag_trunc_chk u_tag_trunc_chk (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .size_we_i    (size_we),
    .size_wdata_i (size_wdata),
    .mode_i       (mode),
    .ccm_flags_i  (flags),
    .calc_mac_i   (calc),
    .rx_tag_i     (rx),
    .start_i      (start),
    .mac_o        (mac),
    .mismatch_o   (mis),
    .done_o       (done)
  );

  initial clk = 1'b0;
  always #(HALF_PERIOD) clk = ~clk;

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] keep_mask(input int n);
    logic [127:0] m = '0;
    for (int r = 0; r < 16; r++)
      if (r < n) m[127 - 8*r -: 8] = 8'hFF;
    return m;
  endfunction

  function automatic logic [127:0] pattern(input int seed);
    logic [127:0] p;
    for (int r = 0; r < 16; r++)
      p[127 - 8*r -: 8] = 8'((seed * 37 + r * 29 + 11) | 1);
    return p;
  endfunction

  function automatic logic [127:0] flip_byte(input logic [127:0] v, input int rank);
    logic [127:0] o = v;
    if (rank < 16) o[127 - 8*rank -: 8] = o[127 - 8*rank -: 8] ^ 8'h5A;
    return o;
  endfunction

  task automatic write_size(input logic [4:0] s);
    @(negedge clk);
    size_we = 1'b1; size_wdata = s;
    @(negedge clk);
    size_we = 1'b0;
  endtask

  // drive at negedge, result registered at the following posedge, sampled at next negedge
  task automatic run(input logic [1:0] m, input logic [2:0] t, input logic [127:0] c, input logic [127:0] r);
    @(negedge clk);
    mode = m; flags = {2'b11, t, 3'b101}; calc = c; rx = r; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; size_we = 1'b0; size_wdata = '0; mode = '0; flags = '0;
    calc = '0; rx = '0; start = 1'b0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 reset mac", mac, '0);
    chk("R10 reset mismatch", {127'd0, mis}, 128'd0);
    chk("R10 reset done", {127'd0, done}, 128'd0);
    rst_n = 1'b1;

    // R9 size register reset value selects 16 bytes
    run(2'd0, 3'd0, pattern(99), flip_byte(pattern(99), 15));
    chk("R9 reset size mismatch", {127'd0, mis}, 128'd1);
    chk("R9 reset size mac", mac, pattern(99));
    chk("R10 done pulse", {127'd0, done}, 128'd1);

    // R10 hold: inputs change without start
    @(negedge clk);
    calc = pattern(5); rx = '0; mode = 2'd1;
    chk("R10 done low", {127'd0, done}, 128'd0);
    repeat (2) @(negedge clk);
    chk("R10 hold mismatch", {127'd0, mis}, 128'd1);
    chk("R10 hold mac", mac, pattern(99));

    for (int i = 0; i < NV; i++) begin
      logic [127:0] c, r;
      c = pattern(i);
      r = flip_byte(c, int'(VEC[i][10:6]));
      write_size(VEC[i][18:14]);
      run(VEC[i][20:19], VEC[i][13:11], c, r);
      chk($sformatf("vec%0d R1-table mismatch", i), {127'd0, mis}, {127'd0, VEC[i][5]});
      chk($sformatf("vec%0d R4 stored mac", i), mac, c & keep_mask(int'(VEC[i][4:0])));
    end

    // R5 padding: all bytes past 8 scrambled in CMAC size 8
    write_size(5'd8);
    run(2'd0, 3'd0, pattern(40), {pattern(40)[127:64], ~pattern(40)[63:0]});
    chk("R5 padding ignored", {127'd0, mis}, 128'd0);
    chk("R4 low bytes zero", mac, {pattern(40)[127:64], 64'd0});

    // R9 write takes effect: size 12 in GCM
    write_size(5'd12);
    run(2'd1, 3'd0, pattern(41), flip_byte(pattern(41), 11));
    chk("R9 written size", {127'd0, mis}, 128'd1);

    // R10 back-to-back starts
    @(negedge clk);
    mode = 2'd2; calc = pattern(50); rx = pattern(50); start = 1'b1;
    @(negedge clk);
    chk("R10 b2b first", {127'd0, mis}, 128'd0);
    rx = flip_byte(pattern(50), 0);
    @(negedge clk);
    start = 1'b0;
    chk("R10 b2b second", {127'd0, mis}, 128'd1);
    chk("R10 b2b done", {127'd0, done}, 128'd1);

    // R9 R10 mid-run reset clears outputs and size
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10 reset clears mac", mac, '0);
    chk("R10 reset clears mismatch", {127'd0, mis}, 128'd0);
    rst_n = 1'b1;
    run(2'd1, 3'd0, pattern(60), flip_byte(pattern(60), 14));
    chk("R9 size back to 0", {127'd0, mis}, 128'd1);
    chk("R3 full mac after reset", mac, pattern(60));

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule